// File: doc/BRIEF.md
# Parameter block fetch sequencer

This block loads a controller's operating parameters from a small table in host memory. The host writes the table's address as two 16-bit halves and picks the structure size. It then writes the control register with the start-fetch bit set. The sequencer arbitrates for the memory bus with a request/grant pair and reads the table one double-word at a time. It holds each bus tenure for no more than two reads and then releases the bus and arbitrates again.

Captured words go into the parameter registers that the descriptor logic reads: a mode word, the receive and transmit ring lengths, and the receive and transmit ring base addresses. The table has trailing words that carry fields this block does not use. Those words are read and discarded. After the last word arrives, a sticky completion flag is set. An interrupt output follows that flag when the host has enabled it.

The host may instead write the parameter registers directly and never request a fetch. Those values then stay in place. A separate run bit lets the descriptor logic start, but only while no fetch is in progress.

Top module: `ibf_sequencer`

## Requirements
- R1: After reset, `bus_req`, `rd_req`, `busy`, `idon`, `irq` and `ring_go` are 0, and all parameter outputs are 0.
- R2: The fetch base address is {high half, low half} with bits 1:0 forced to 0. Word k of the table is read at base + 4*k, in increasing k.
- R3: A fetch starts only on a control write (`host_sel`=2) with `host_wdata[0]`=1. Without such a write, `bus_req` stays 0.
- R4: Within one grant (one `bus_req` high period), at most two reads complete. Between tenures, `bus_req` is low for at least one cycle. `rd_req` is high only while `bus_gnt` is high.
- R5: The control write also sets the size bit from `host_wdata[4]`. With the size bit at 1, the table is 7 words and takes 4 tenures. With it at 0, the table is 6 words and takes 3 tenures.
- R6: Table word 0 loads `mode`. Word 1 loads `rx_len` from bits 15:0 and `tx_len` from bits 31:16. Word 2 loads `rx_base` and word 3 loads `tx_base`. Later words change no output.
- R7: `idon` rises in the cycle `busy` falls after the last word. It stays set until a control write with `host_wdata[3]`=1 clears it.
- R8: `irq` is high exactly when `idon` is set and the enable bit is set. The enable bit is loaded from `host_wdata[2]` on every control write.
- R9: A start-fetch request written while `busy` is high is ignored. No further tenure follows the current fetch.
- R10: Writes with `host_sel` 3, 4, 5 and 6 load `mode`, lengths (rx in bits 15:0, tx in bits 31:16), `rx_base` and `tx_base` directly. These writes start no fetch.
- R11: A control write with `host_wdata[1]`=1 sets a sticky run bit. `ring_go` is the run bit while `busy` is low, and 0 while a fetch is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Register select: 0 addr low, 1 addr high, 2 control, 3 mode, 4 lengths, 5 rx base, 6 tx base |
| host_wdata | input | 32 | Host write data |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus grant |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | 32 | Read byte address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| mode | output | 32 | Captured mode word |
| rx_base | output | 32 | Receive ring base |
| tx_base | output | 32 | Transmit ring base |
| rx_len | output | 16 | Receive ring length |
| tx_len | output | 16 | Transmit ring length |
| idon | output | 1 | Sticky fetch-complete flag |
| irq | output | 1 | Interrupt |
| busy | output | 1 | Fetch in progress |
| ring_go | output | 1 | Descriptor logic may run |

## Verification
The fetch is run in both size modes. Telling them apart relies on the word count and on the number of grant periods: 7 words over four tenures against 6 words over three. A base address with its two low bits set shows that alignment is forced rather than passed through. Memory returns a distinct, address-derived value at every location, so any swap of word-to-register mapping or a skipped word shows up. A second start request written mid-fetch and a run of direct register writes with no start request both expose any spurious extra bus activity.

// File: rtl/ibf_pkg.sv
package ibf_pkg;
    localparam logic [2:0] SEL_ALO   = 3'd0;
    localparam logic [2:0] SEL_AHI   = 3'd1;
    localparam logic [2:0] SEL_CTRL  = 3'd2;
    localparam logic [2:0] SEL_MODE  = 3'd3;
    localparam logic [2:0] SEL_LENS  = 3'd4;
    localparam logic [2:0] SEL_RXB   = 3'd5;
    localparam logic [2:0] SEL_TXB   = 3'd6;

    localparam int CTL_INIT = 0;
    localparam int CTL_STRT = 1;
    localparam int CTL_IENA = 2;
    localparam int CTL_IDCL = 3;
    localparam int CTL_WIDE = 4;

    localparam int PARAM_WORDS = 4;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ARB,
        S_READ,
        S_GAP
    } fetch_st_e;
endpackage

// File: rtl/ibf_fetch_fsm.sv
module ibf_fetch_fsm
    import ibf_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int WORDS_WIDE   = 7,
    parameter int WORDS_NARROW = 6,
    parameter int BURST        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic [ADDR_W-1:0] base,
    input  logic              bus_gnt,
    input  logic              rd_ack,
    output logic              bus_req,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cap_en,
    output logic [$clog2(WORDS_WIDE+1)-1:0] cap_idx,
    output logic              busy,
    output logic              done
);
    localparam int IDX_W  = $clog2(WORDS_WIDE + 1);
    localparam int BEAT_W = (BURST > 1) ? $clog2(BURST) : 1;
    localparam logic [IDX_W-1:0]  LAST_WIDE   = IDX_W'(WORDS_WIDE - 1);
    localparam logic [IDX_W-1:0]  LAST_NARROW = IDX_W'(WORDS_NARROW - 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT   = BEAT_W'(BURST - 1);

    typedef struct packed {
        fetch_st_e          st;
        logic [IDX_W-1:0]   idx;
        logic [BEAT_W-1:0]  beat;
        logic [IDX_W-1:0]   last;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d      = q;
        done   = 1'b0;
        cap_en = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st   = S_ARB;
                    d.idx  = '0;
                    d.beat = '0;
                    d.last = wide ? LAST_WIDE : LAST_NARROW;
                end
            end
            S_ARB: begin
                if (bus_gnt) d.st = S_READ;
            end
            S_READ: begin
                if (rd_ack) begin
                    cap_en = 1'b1;
                    if (q.idx == q.last) begin
                        d.st = S_IDLE;
                        done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        if (q.beat == LAST_BEAT) begin
                            d.beat = '0;
                            d.st   = S_GAP;
                        end else begin
                            d.beat = q.beat + 1'b1;
                        end
                    end
                end
            end
            S_GAP:   d.st = S_ARB;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, idx: '0, beat: '0, last: '0};
        end else begin
            q <= d;
        end
    end

    assign bus_req = (q.st == S_ARB) || (q.st == S_READ);
    assign rd_req  = (q.st == S_READ);
    assign busy    = (q.st != S_IDLE);
    assign cap_idx = q.idx;
    assign rd_addr = base + {{(ADDR_W-IDX_W-2){1'b0}}, q.idx, 2'b00};
endmodule

// File: rtl/ibf_param_regs.sv
module ibf_param_regs
    import ibf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode,
    output logic [DATA_W-1:0] rx_base,
    output logic [DATA_W-1:0] tx_base,
    output logic [LEN_W-1:0]  rx_len,
    output logic [LEN_W-1:0]  tx_len
);
    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] rxb;
        logic [DATA_W-1:0] txb;
        logic [LEN_W-1:0]  rxl;
        logic [LEN_W-1:0]  txl;
    } prm_t;

    prm_t q, d;

    always_comb begin
        d = q;
        if (we) begin
            case (sel)
                SEL_MODE: d.mode = wdata;
                SEL_LENS: begin
                    d.rxl = wdata[LEN_W-1:0];
                    d.txl = wdata[2*LEN_W-1:LEN_W];
                end
                SEL_RXB: d.rxb = wdata;
                SEL_TXB: d.txb = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode    = q.mode;
    assign rx_base = q.rxb;
    assign tx_base = q.txb;
    assign rx_len  = q.rxl;
    assign tx_len  = q.txl;
endmodule

// File: rtl/ibf_sequencer.sv
module ibf_sequencer
    import ibf_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int LEN_W        = 16,
    parameter int WORDS_WIDE   = 7,
    parameter int WORDS_NARROW = 6,
    parameter int BURST        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [2:0]        host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] mode,
    output logic [DATA_W-1:0] rx_base,
    output logic [DATA_W-1:0] tx_base,
    output logic [LEN_W-1:0]  rx_len,
    output logic [LEN_W-1:0]  tx_len,
    output logic              idon,
    output logic              irq,
    output logic              busy,
    output logic              ring_go
);
    localparam int HALF_W = ADDR_W / 2;
    localparam int IDX_W  = $clog2(WORDS_WIDE + 1);

    typedef struct packed {
        logic [HALF_W-1:0] alo;
        logic [HALF_W-1:0] ahi;
        logic              iena;
        logic              wide;
        logic              idon;
        logic              run;
    } ctl_t;

    ctl_t q, d;

    logic              ctl_wr, start, done, cap_en;
    logic [IDX_W-1:0]  cap_idx;
    logic [ADDR_W-1:0] base;
    logic              pw_we;
    logic [2:0]        pw_sel;
    logic [DATA_W-1:0] pw_data;

    assign ctl_wr = host_we && (host_sel == SEL_CTRL);
    assign start  = ctl_wr && host_wdata[CTL_INIT];
    assign base   = {q.ahi, q.alo[HALF_W-1:2], 2'b00};

    always_comb begin
        d = q;
        if (host_we && host_sel == SEL_ALO) d.alo = host_wdata[HALF_W-1:0];
        if (host_we && host_sel == SEL_AHI) d.ahi = host_wdata[HALF_W-1:0];
        if (ctl_wr) begin
            d.iena = host_wdata[CTL_IENA];
            d.wide = host_wdata[CTL_WIDE];
            if (host_wdata[CTL_STRT]) d.run  = 1'b1;
            if (host_wdata[CTL_IDCL]) d.idon = 1'b0;
        end
        if (done) d.idon = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    ibf_fetch_fsm #(
        .ADDR_W(ADDR_W), .WORDS_WIDE(WORDS_WIDE),
        .WORDS_NARROW(WORDS_NARROW), .BURST(BURST)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(d.wide),
        .base(base), .bus_gnt(bus_gnt), .rd_ack(rd_ack),
        .bus_req(bus_req), .rd_req(rd_req), .rd_addr(rd_addr),
        .cap_en(cap_en), .cap_idx(cap_idx), .busy(busy), .done(done)
    );

    // Fetched words map onto the same write port as direct host writes.
    always_comb begin
        if (cap_en) begin
            pw_we   = (cap_idx < IDX_W'(PARAM_WORDS));
            pw_sel  = SEL_MODE + 3'(cap_idx);
            pw_data = rd_data;
        end else begin
            pw_we   = host_we;
            pw_sel  = host_sel;
            pw_data = host_wdata;
        end
    end

    ibf_param_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(pw_we), .sel(pw_sel), .wdata(pw_data),
        .mode(mode), .rx_base(rx_base), .tx_base(tx_base),
        .rx_len(rx_len), .tx_len(tx_len)
    );

    assign idon    = q.idon;
    assign irq     = q.idon & q.iena;
    assign ring_go = q.run & ~busy;
endmodule

// File: rtl/ibf_sequencer_chk.sv
module ibf_sequencer_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int BURST  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [2:0]        host_sel,
    input logic [DATA_W-1:0] host_wdata,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic              idon,
    input logic              busy,
    input logic              ring_go
);
    logic [7:0] beats_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 beats_q <= '0;
        else if (!bus_req)          beats_q <= '0;
        else if (rd_req && rd_ack)  beats_q <= beats_q + 1'b1;
    end

    a_r4_tenure_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |-> (beats_q < 8'(BURST)));

    a_r4_read_granted: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> bus_gnt);

    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[1:0] == 2'b00));

    a_r3_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(host_we && host_sel == 3'd2 && host_wdata[0]));

    a_r7_idon_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idon) |-> $fell(busy));

    a_r7_idon_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idon) |-> $past(host_we && host_sel == 3'd2 && host_wdata[3]));

    a_r11_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ring_go);
endmodule

bind ibf_sequencer ibf_sequencer_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST(BURST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .idon(idon),
    .busy(busy), .ring_go(ring_go)
);

// File: tb/ibf_sequencer_test.sv
module ibf_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_sel = '0;
    logic [31:0] host_wdata = '0;
    logic        bus_req, bus_gnt = 1'b0;
    logic        rd_req, rd_ack = 1'b0;
    logic [31:0] rd_addr, rd_data = '0;
    logic [31:0] mode, rx_base, tx_base;
    logic [15:0] rx_len, tx_len;
    logic        idon, irq, busy, ring_go;

    int checks = 0;
    int errors = 0;
    int tenures = 0;
    int beats = 0;
    int max_beats = 0;
    int gnt_wait = 0;
    int cycles = 0;
    logic prev_req = 1'b0;
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;

    ibf_sequencer uut (.*);

    function automatic logic [31:0] memword(input logic [31:0] a);
        return {a[15:0] ^ 16'h5AC3, a[31:16] + 16'h0101};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Arbiter and memory model; monitor pops expected addresses.
    always @(negedge clk) begin
        if (bus_req && !prev_req) begin
            tenures++;
            beats = 0;
        end
        prev_req = bus_req;
        if (!bus_req) begin
            bus_gnt  = 1'b0;
            gnt_wait = 0;
        end else if (!bus_gnt) begin
            gnt_wait++;
            if (gnt_wait >= 2) bus_gnt = 1'b1;
        end
        if (rd_req && !rd_ack) begin
            logic [31:0] e;
            rd_ack  = 1'b1;
            rd_data = memword(rd_addr);
            beats++;
            if (beats > max_beats) max_beats = beats;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hDEAD_BEEF;
            chk(rd_addr == e, "R2 read address", rd_addr, e);
        end else begin
            rd_ack = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic hwrite(input logic [2:0] s, input logic [31:0] v);
        @(negedge clk);
        host_we = 1'b1; host_sel = s; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic fetch(input logic [15:0] hi, input logic [15:0] lo,
                         input bit wide, input bit iena, input string tag);
        logic [31:0] b;
        int nw;
        b  = {hi, lo[15:2], 2'b00};
        nw = wide ? 7 : 6;
        hwrite(3'd0, {16'h0, lo});
        hwrite(3'd1, {16'h0, hi});
        for (int k = 0; k < nw; k++) exp_q.push_back(b + 32'(4 * k));
        tenures = 0; max_beats = 0;
        hwrite(3'd2, {27'h0, wide, 1'b1, iena, 1'b0, 1'b1});
        wait_idle();
        chk(exp_q.size() == 0, {"R5 words read ", tag}, exp_q.size(), 0);
        chk(tenures == (wide ? 4 : 3), {"R5 tenures ", tag}, tenures, wide ? 4 : 3);
        chk(max_beats <= 2, {"R4 beats per tenure ", tag}, max_beats, 2);
        chk(mode == memword(b), {"R6 mode ", tag}, mode, memword(b));
        chk({tx_len, rx_len} == memword(b + 4), {"R6 lengths ", tag},
            {tx_len, rx_len}, memword(b + 4));
        chk(rx_base == memword(b + 8), {"R6 rx base ", tag}, rx_base, memword(b + 8));
        chk(tx_base == memword(b + 12), {"R6 tx base ", tag}, tx_base, memword(b + 12));
        chk(idon == 1'b1, {"R7 idon set ", tag}, idon, 1);
        chk(irq == iena, {"R8 irq follows enable ", tag}, irq, iena);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({bus_req, rd_req, busy, idon, irq, ring_go} == 0, "R1 outputs",
            {bus_req, rd_req, busy, idon, irq, ring_go}, 0);
        chk({mode, rx_base, tx_base, rx_len} == 0, "R1 params", mode, 0);

        // R10 direct writes, R3 no fetch without start bit
        tenures = 0;
        hwrite(3'd3, 32'h1111_2222);
        hwrite(3'd4, 32'h0040_0080);
        hwrite(3'd5, 32'hAAAA_0010);
        hwrite(3'd6, 32'hBBBB_0020);
        hwrite(3'd2, 32'h0000_0004);
        repeat (10) @(negedge clk);
        chk(tenures == 0 && !busy, "R3 no fetch", tenures, 0);
        chk(mode == 32'h1111_2222, "R10 mode kept", mode, 32'h1111_2222);
        chk(rx_len == 16'h0080 && tx_len == 16'h0040, "R10 lengths",
            {tx_len, rx_len}, 32'h0040_0080);
        chk(rx_base == 32'hAAAA_0010 && tx_base == 32'hBBBB_0020, "R10 bases",
            rx_base, 32'hAAAA_0010);

        // Wide fetch, unaligned low half (R2 forcing), interrupt disabled
        fetch(16'h1234, 16'h0103, 1'b1, 1'b0, "wide");
        hwrite(3'd2, 32'h0000_0004);
        chk(irq == 1'b1, "R8 irq after enable", irq, 1);
        hwrite(3'd2, 32'h0000_000C);
        chk(idon == 1'b0 && irq == 1'b0, "R7 idon cleared", {idon, irq}, 0);

        // Narrow fetch with interrupt enabled and run bit (R11)
        for (int k = 0; k < 6; k++) exp_q.push_back(32'h0008_4400 + 32'(4 * k));
        hwrite(3'd0, 32'h4400);
        hwrite(3'd1, 32'h0008);
        tenures = 0; max_beats = 0;
        hwrite(3'd2, 32'h0000_0007);
        chk(busy && !ring_go, "R11 go held during fetch", ring_go, 0);
        // R9 second start during fetch is ignored
        hwrite(3'd2, 32'h0000_0005);
        wait_idle();
        repeat (20) @(negedge clk);
        chk(tenures == 3, "R9 no extra tenure", tenures, 3);
        chk(exp_q.size() == 0, "R5 narrow words", exp_q.size(), 0);
        chk(ring_go == 1'b1, "R11 go after fetch", ring_go, 1);
        chk(irq == 1'b1, "R8 irq enabled", irq, 1);
        chk(rx_base == memword(32'h0008_4408), "R6 narrow rx base", rx_base,
            memword(32'h0008_4408));
        exp_q.delete();

        // Another wide fetch to a different region
        fetch(16'hFFF0, 16'hFFF8, 1'b1, 1'b1, "wide2");
        fetch(16'h0002, 16'h0040, 1'b0, 1'b0, "narrow2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule